// File: doc/BRIEF.md
# Event and Cycle Performance Counter Unit

This unit counts hardware events for software profiling. It holds a parameterised number of 32-bit event counters, each with its own 8-bit event code that picks one line of the `evt_in` vector, plus one free-running 32-bit cycle counter. Software drives all of it through a flat word-addressed register port. Reads are combinational from the current register state. A write takes effect at the rising clock edge on which `reg_en` and `reg_we` are both high.

Event counters are not mapped one per address. Software first writes a counter index into the select register. The event-type and event-count addresses then act on that counter. The cycle counter has a direct address of its own. Enables for counting and for interrupts are changed through separate set and clear addresses, so no read-modify-write is needed. Each counter that wraps from all ones to zero raises a sticky overflow flag. The single `irq` output is high while any flag that has its interrupt enabled is pending.

The intended sampling use is to preload a counter with the two's complement of a period N. Software then takes the interrupt N events later, clears the flag and reloads the counter.

Top module: `pmu_core`

## Requirements
- R1: After reset all enables, overflow flags, the select index, the event codes and all counts are zero. The control register (address 0) reads with bit 0 = global enable, bits 15:11 = NUM_CTR and bits 31:24 = ID_CODE. Writes to the read-only fields are ignored.
- R2: Counter enable uses two addresses, set (1) and clear (2). A 1 in bit n of a write to set enables event counter n, and a 1 in bit n of a write to clear disables it. Bit 31 controls the cycle counter in both. Zero bits leave their counter unchanged. Both addresses read back the enable mask, and bits of unimplemented counters read 0.
- R3: Interrupt enable uses the same set (3) and clear (4) scheme, with one bit per event counter and bit 31 for the cycle counter.
- R4: While control bit 0 is clear, no counter advances.
- R5: While the global enable and its own enable are set, an event counter increments by one on each clock whose `evt_in` line, chosen by its 8-bit event code, is high. A code of NUM_EVT or above never counts.
- R6: The select register (address 6, 5 bits) chooses the counter reached through the event-type (7, low 8 bits) and event-count (8) addresses. With an index of NUM_CTR or above, both addresses read zero and writes to them change no counter.
- R7: The cycle counter (address 9, direct) increments on every clock while the global enable and enable bit 31 are set.
- R8: A counter that increments from 0xFFFFFFFF wraps to 0 and sets overflow bit n for event counter n, or bit 31 for the cycle counter. A counter preloaded with -N therefore overflows on its Nth increment.
- R9: The overflow register (address 5) is write-one-to-clear, and a 0 bit leaves its flag unchanged. A wrap on the same edge as a clear of that bit leaves the flag set.
- R10: `irq` is high exactly while some overflow flag and the matching interrupt-enable bit are both set.
- R11: A software write to a count register on the same edge as an increment loads the written value, and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| evt_in | input | NUM_EVT | Event pulse lines, one per event code |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest cases to reach from the ports are collisions on a single edge: a wrap that lands on the same edge as a clear of its own flag, and a software load that lands on the same edge as an increment. The stimulus uses the global enable as a gate it can time exactly. It first preloads a counter to all ones with counting off, then turns counting on with one write. The colliding write goes out on the very next cycle, and a third write stops counting. The edge on which each increment happens is therefore known. The expected flag and count follow from that edge alone.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int SEL_W   = 5;
    localparam int CODE_W  = 8;
    localparam int CYC_BIT = 31;

    // word addresses of the register port
    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] A_CEN_SET = 4'd1;
    localparam logic [ADDR_W-1:0] A_CEN_CLR = 4'd2;
    localparam logic [ADDR_W-1:0] A_IEN_SET = 4'd3;
    localparam logic [ADDR_W-1:0] A_IEN_CLR = 4'd4;
    localparam logic [ADDR_W-1:0] A_OVF     = 4'd5;
    localparam logic [ADDR_W-1:0] A_SEL     = 4'd6;
    localparam logic [ADDR_W-1:0] A_EVTYPE  = 4'd7;
    localparam logic [ADDR_W-1:0] A_EVCNT   = 4'd8;
    localparam logic [ADDR_W-1:0] A_CYC     = 4'd9;

    // control register field positions
    localparam int CTL_EN_BIT = 0;
    localparam int CTL_N_LO   = 11;
    localparam int CTL_ID_LO  = 24;

    typedef struct packed {
        logic              glob;
        logic [DATA_W-1:0] cen;
        logic [DATA_W-1:0] ien;
        logic [DATA_W-1:0] ovf;
        logic [SEL_W-1:0]  sel;
    } ctl_state_t;

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld)
            cnt_d = ld_val;             // software load wins over the increment
        else if (inc)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign wrap = inc && !ld && (&cnt_q);

    p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld) |=> (cnt_q == $past(cnt_q) + W'(1)));

    p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt_q == $past(ld_val)));

endmodule

// File: rtl/pmu_evt_slot.sv
module pmu_evt_slot
    import pmu_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EVT-1:0] evt_vec,
    input  logic              run,
    input  logic              ty_we,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] cnt,
    output logic              wrap
);

    logic [CODE_W-1:0] code_d, code_q;
    logic              hit;

    always_comb begin
        code_d = ty_we ? wdata[CODE_W-1:0] : code_q;
        hit    = 1'b0;
        for (int j = 0; j < NUM_EVT; j++)
            if (code_q == CODE_W'(j)) hit = evt_vec[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    assign code = code_q;

    pmu_counter #(.W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (run && hit),
        .ld     (cnt_we),
        .ld_val (wdata),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> $stable(cnt));

endmodule

// File: rtl/pmu_core.sv
module pmu_core
    import pmu_pkg::*;
#(
    parameter int          NUM_CTR = 4,
    parameter int          NUM_EVT = 8,
    parameter logic [7:0]  ID_CODE = 8'hA7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_en,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);

    localparam logic [DATA_W-1:0] IMPL_MASK =
        ((DATA_W'(1) << NUM_CTR) - DATA_W'(1)) | (DATA_W'(1) << CYC_BIT);

    ctl_state_t st_d, st_q;

    logic [DATA_W-1:0] slot_cnt  [NUM_CTR];
    logic [CODE_W-1:0] slot_code [NUM_CTR];
    logic [NUM_CTR-1:0] slot_wrap;
    logic [DATA_W-1:0] cyc_cnt;
    logic              cyc_wrap;
    logic [DATA_W-1:0] wrap_all;
    logic              wr;
    logic              sel_ok;
    logic              cyc_ld;

    assign wr     = reg_en && reg_we;
    assign sel_ok = (int'(st_q.sel) < NUM_CTR);
    assign cyc_ld = wr && (reg_addr == A_CYC);

    // ---------------- counters ----------------
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        logic sel_me;
        assign sel_me = (st_q.sel == SEL_W'(i));

        pmu_evt_slot #(.NUM_EVT(NUM_EVT)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_vec (evt_in),
            .run     (st_q.glob && st_q.cen[i]),
            .ty_we   (wr && sel_me && (reg_addr == A_EVTYPE)),
            .cnt_we  (wr && sel_me && (reg_addr == A_EVCNT)),
            .wdata   (reg_wdata),
            .code    (slot_code[i]),
            .cnt     (slot_cnt[i]),
            .wrap    (slot_wrap[i])
        );
    end

    pmu_counter #(.W(DATA_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (st_q.glob && st_q.cen[CYC_BIT]),
        .ld     (cyc_ld),
        .ld_val (reg_wdata),
        .cnt    (cyc_cnt),
        .wrap   (cyc_wrap)
    );

    always_comb begin
        wrap_all                = '0;
        wrap_all[NUM_CTR-1:0]   = slot_wrap;
        wrap_all[CYC_BIT]       = cyc_wrap;
    end

    // ---------------- control state ----------------
    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (reg_addr)
                A_CTRL:    st_d.glob = reg_wdata[CTL_EN_BIT];
                A_CEN_SET: st_d.cen  = st_q.cen | (reg_wdata & IMPL_MASK);
                A_CEN_CLR: st_d.cen  = st_q.cen & ~reg_wdata;
                A_IEN_SET: st_d.ien  = st_q.ien | (reg_wdata & IMPL_MASK);
                A_IEN_CLR: st_d.ien  = st_q.ien & ~reg_wdata;
                A_OVF:     st_d.ovf  = st_q.ovf & ~reg_wdata;
                A_SEL:     st_d.sel  = reg_wdata[SEL_W-1:0];
                default: ;
            endcase
        end
        // a wrap on the clearing edge keeps its flag
        st_d.ovf = st_d.ovf | wrap_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = |(st_q.ovf & st_q.ien);

    // ---------------- read mux ----------------
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTL_EN_BIT]          = st_q.glob;
                reg_rdata[CTL_N_LO +: SEL_W]   = SEL_W'(NUM_CTR);
                reg_rdata[CTL_ID_LO +: 8]      = ID_CODE;
            end
            A_CEN_SET, A_CEN_CLR: reg_rdata = st_q.cen;
            A_IEN_SET, A_IEN_CLR: reg_rdata = st_q.ien;
            A_OVF:                reg_rdata = st_q.ovf;
            A_SEL:                reg_rdata[SEL_W-1:0] = st_q.sel;
            A_EVTYPE: begin
                for (int i = 0; i < NUM_CTR; i++)
                    if (st_q.sel == SEL_W'(i)) reg_rdata[CODE_W-1:0] = slot_code[i];
            end
            A_EVCNT: begin
                for (int i = 0; i < NUM_CTR; i++)
                    if (st_q.sel == SEL_W'(i)) reg_rdata = slot_cnt[i];
            end
            A_CYC:                reg_rdata = cyc_cnt;
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.glob && !cyc_ld) |=> $stable(cyc_cnt));

    p_cyc_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_wrap |=> st_q.ovf[CYC_BIT]);

    p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf[CYC_BIT] && !(wr && reg_addr == A_OVF && reg_wdata[CYC_BIT]))
        |=> st_q.ovf[CYC_BIT]);

    p_cen_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_addr == A_CEN_SET && reg_wdata[CYC_BIT]) |=> st_q.cen[CYC_BIT]);

    p_ien_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_addr == A_IEN_CLR && reg_wdata[CYC_BIT]) |=> !st_q.ien[CYC_BIT]);

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ien == '0) |-> !irq);

    p_sel_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok && reg_addr == A_EVCNT) |-> (reg_rdata == '0));

endmodule

// File: tb/pmu_core_tb.sv
module pmu_core_tb;
    import pmu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int NE = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_en = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [NE-1:0]     evt_in = '0;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pmu_core #(.NUM_CTR(NC), .NUM_EVT(NE), .ID_CODE(8'hA7)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .irq(irq)
    );

    // monitor: pops expected items and compares them against the outputs
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // driver tasks: entered just after a falling edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // exactly k counting edges
    task automatic run(input int k);
        wr(A_CTRL, 32'h1);
        idle(k - 1);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic rd_cnt(input int idx, input logic [31:0] e, input string tag);
        wr(A_SEL, 32'(idx));
        rd(A_EVCNT, e, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and read-only fields
        rd(A_CTRL, 32'hA700_2000, "R1 ctrl after reset");
        rd(A_CEN_SET, 32'h0, "R1 cen after reset");
        rd(A_OVF, 32'h0, "R1 ovf after reset");
        rd(A_CYC, 32'h0, "R1 cyc after reset");
        chk_irq(1'b0, "R1 irq after reset");
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, 32'hA700_2001, "R1 ro fields ignore write");
        wr(A_CTRL, 32'h0);

        // R2 counter enable set/clear
        wr(A_CEN_SET, 32'hFFFF_FFFF);
        rd(A_CEN_SET, 32'h8000_000F, "R2 set all implemented");
        wr(A_CEN_CLR, 32'h0000_0008);
        rd(A_CEN_CLR, 32'h8000_0007, "R2 clear bit3");
        wr(A_CEN_SET, 32'h0);
        rd(A_CEN_SET, 32'h8000_0007, "R2 zero set no effect");
        wr(A_CEN_CLR, 32'h0);
        rd(A_CEN_SET, 32'h8000_0007, "R2 zero clear no effect");

        // R3 interrupt enable set/clear
        wr(A_IEN_SET, 32'hFFFF_FFFF);
        rd(A_IEN_SET, 32'h8000_000F, "R3 set all implemented");
        wr(A_IEN_CLR, 32'h0000_000F);
        rd(A_IEN_CLR, 32'h8000_0000, "R3 clear low bits");
        wr(A_IEN_CLR, 32'h0);
        rd(A_IEN_SET, 32'h8000_0000, "R3 zero clear no effect");

        // R6 event codes through the select register
        wr(A_SEL, 32'd0); wr(A_EVTYPE, 32'd2);
        wr(A_SEL, 32'd1); wr(A_EVTYPE, 32'd5);
        wr(A_SEL, 32'd2); wr(A_EVTYPE, 32'd200);
        wr(A_SEL, 32'd3); wr(A_EVTYPE, 32'd0);
        wr(A_SEL, 32'd1);
        rd(A_EVTYPE, 32'd5, "R6 event code readback");

        // R4 no counting while globally disabled
        evt_in = 8'b0010_0101;
        idle(5);
        rd_cnt(0, 32'd0, "R4 ctr0 frozen");
        rd(A_CYC, 32'd0, "R4 cyc frozen");

        // R5 R7 counting
        run(10);
        rd_cnt(0, 32'd10, "R5 ctr0 code2");
        rd_cnt(1, 32'd10, "R5 ctr1 code5");
        rd_cnt(2, 32'd0, "R5 code out of range");
        rd_cnt(3, 32'd0, "R2 disabled ctr3");
        rd(A_CYC, 32'd10, "R7 cyc count");
        evt_in = 8'b0000_0100;
        run(3);
        rd_cnt(0, 32'd13, "R5 ctr0 line high");
        rd_cnt(1, 32'd10, "R5 ctr1 line low");
        rd(A_CYC, 32'd13, "R7 cyc count 2");

        // R6 out-of-range select
        wr(A_SEL, 32'd7);
        rd(A_EVCNT, 32'd0, "R6 oor count reads 0");
        rd(A_EVTYPE, 32'd0, "R6 oor type reads 0");
        wr(A_EVCNT, 32'h123);
        wr(A_EVTYPE, 32'd1);
        rd_cnt(3, 32'd0, "R6 oor count write ignored");
        rd(A_EVTYPE, 32'd0, "R6 oor type write ignored");
        wr(A_SEL, 32'd0);
        rd(A_EVTYPE, 32'd2, "R6 ctr0 type intact");

        // R8 preload and overflow
        wr(A_EVCNT, 32'hFFFF_FFFD);
        run(2);
        rd(A_EVCNT, 32'hFFFF_FFFF, "R8 before wrap");
        rd(A_OVF, 32'h0, "R8 no flag yet");
        run(1);
        rd(A_EVCNT, 32'h0, "R8 wrapped");
        rd(A_OVF, 32'h1, "R8 flag bit0");
        chk_irq(1'b0, "R10 masked flag");
        wr(A_IEN_SET, 32'h1);
        chk_irq(1'b1, "R10 enabled flag");
        wr(A_CYC, 32'hFFFF_FFFE);
        run(2);
        rd(A_CYC, 32'h0, "R8 cyc wrapped");
        rd(A_OVF, 32'h8000_0001, "R8 cyc flag bit31");

        // R9 write-one-to-clear
        wr(A_OVF, 32'h0);
        rd(A_OVF, 32'h8000_0001, "R9 zero write no effect");
        wr(A_OVF, 32'h1);
        rd(A_OVF, 32'h8000_0000, "R9 clear bit0");
        chk_irq(1'b1, "R10 cyc flag enabled");
        wr(A_IEN_CLR, 32'h8000_0000);
        chk_irq(1'b0, "R10 cyc flag masked");
        wr(A_OVF, 32'h8000_0000);
        rd(A_OVF, 32'h0, "R9 clear bit31");

        // R9 wrap on the clearing edge keeps the flag
        wr(A_EVCNT, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h1);
        wr(A_OVF, 32'h1);
        wr(A_CTRL, 32'h0);
        rd(A_OVF, 32'h1, "R9 set beats clear");
        rd(A_EVCNT, 32'h1, "R8 count after collision");

        // R11 load beats increment
        wr(A_CTRL, 32'h1);
        wr(A_EVCNT, 32'd100);
        wr(A_CTRL, 32'h0);
        rd(A_EVCNT, 32'd101, "R11 event load priority");
        wr(A_CTRL, 32'h1);
        wr(A_CYC, 32'd50);
        wr(A_CTRL, 32'h0);
        rd(A_CYC, 32'd51, "R11 cyc load priority");

        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule